// File: doc/BRIEF.md
# Half-Bridge Leg Gate Controller

This block is the digital control for one leg of an inverter bridge. It accepts a high-side command that is true when high, a low-side command that is true when low, and a halt input that stops the leg when low. All three are assumed already synchronous to the clock. From them it produces two registered gate-enable outputs, one for the upper switch and one for the lower switch.

The controller never lets both switches conduct at once. A command pair that asks for both switches is treated as a fault, and both gates are turned off. Whenever a gate turns off, a shared counter holds every turn-on back for a programmable number of cycles. This dead time holds even when one signal drives both command pins. A digitised supply level goes through a two-threshold hysteresis stage, and while the supply is low both gates are kept off.

Three instances make a three-phase bridge.

Top module: `leg_gate_ctrl`

## Requirements
- R1: During reset both gates are low and the dead-time counter is cleared. The first turn-on after reset is therefore not delayed by dead time: once the supply flag has cleared, a request reaches its gate at the next clock edge.
- R2: A high-side request is `hi_cmd`=1 with `lo_cmd_n`=1. When no dead time is pending, it drives `gate_hi` high one edge later and keeps `gate_lo` low.
- R3: A low-side request is `hi_cmd`=0 with `lo_cmd_n`=0. When no dead time is pending, it drives `gate_lo` high one edge later and keeps `gate_hi` low.
- R4: The pair `hi_cmd`=1 with `lo_cmd_n`=0 is an interlock condition. Both gates are low one edge later.
- R5: The idle pair (`hi_cmd`=0, `lo_cmd_n`=1) turns both gates off one edge later, so the leg floats.
- R6: `gate_hi` and `gate_lo` are never high in the same cycle.
- R7: When either gate falls, no gate may rise until `DEAD_CYC` cycles have passed with both gates low. A pending request rises exactly at edge `DEAD_CYC`+1 after the fall. This holds for a turn-on of the same side and of the opposite side.
- R8: A request that arrives more than `DEAD_CYC` cycles after the last turn-off is followed at the next edge.
- R9: If one signal drives both `hi_cmd` and `lo_cmd_n`, the leg switches in a complementary way, with the same dead time as in R7 on every transition.
- R10: `halt_n`=0 turns both gates off one edge later, whatever the commands are. This forced turn-off starts a dead time like any other turn-off.
- R11: The supply flag sets when `sup_lvl` < `UV_OFF`, clears when `sup_lvl` >= `UV_ON`, and otherwise holds its state. The flag is registered, and both gates are off one edge after the flag is set.
- R12: The supply flag is set in reset. Both gates stay low until `sup_lvl` >= `UV_ON` has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd | input | 1 | High-side command, active high |
| lo_cmd_n | input | 1 | Low-side command, active low |
| halt_n | input | 1 | Leg stop, active low |
| sup_lvl | input | LVL_W | Digitised supply level |
| gate_hi | output | 1 | Upper switch gate enable |
| gate_lo | output | 1 | Lower switch gate enable |

## Verification
The leg is driven with each of the four command pairs, and each pair is applied both with the dead-time counter still running and after it has expired. This separates a request blocked by dead time from a request refused by interlock or idle. Same-side and opposite-side turn-ons after a fall are timed to the exact edge, and so are the transitions with one tied signal, which confirms that the gap is exactly `DEAD_CYC` cycles long. The supply level is stepped below the lower threshold, between the thresholds and above the upper threshold, which shows that a level between the thresholds keeps the previous flag state in both directions.

// File: rtl/leg_pkg.sv
package leg_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_pair_t;
endpackage

// File: rtl/leg_cmd_decode.sv
module leg_cmd_decode
  import leg_pkg::*;
(
  input  logic      hi_cmd,
  input  logic      lo_cmd_n,
  input  logic      halt_n,
  input  logic      uv,
  output leg_pair_t req
);
  logic hi_act;
  logic lo_act;
  logic permit;

  always_comb begin
    hi_act = hi_cmd;
    lo_act = ~lo_cmd_n;
    permit = halt_n & ~uv;
    // a side is requested only when the other side is not
    req.hi = permit & hi_act & ~lo_act;
    req.lo = permit & lo_act & ~hi_act;
  end
endmodule

// File: rtl/leg_uv_hyst.sv
module leg_uv_hyst #(
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned UV_ON  = 120,
  parameter int unsigned UV_OFF = 105
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl,
  output logic             uv_o
);
  localparam logic [LVL_W-1:0] ON_L  = LVL_W'(UV_ON);
  localparam logic [LVL_W-1:0] OFF_L = LVL_W'(UV_OFF);

  logic uv_q;
  logic uv_d;

  always_comb begin
    uv_d = uv_q;
    if (lvl < OFF_L)       uv_d = 1'b1;
    else if (lvl >= ON_L)  uv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uv_q <= 1'b1;
    else        uv_q <= uv_d;
  end

  assign uv_o = uv_q;

  // R11: a low level always sets the flag
  p_uv_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl < OFF_L) |=> uv_q);
  // R11: between thresholds the flag does not move
  p_uv_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl >= OFF_L && lvl < ON_L) |=> $stable(uv_q));
endmodule

// File: rtl/leg_dead_timer.sv
module leg_dead_timer #(
  parameter int unsigned DEAD_CYC = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int unsigned CNT_W = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DEAD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) cnt_d = LOAD_VAL;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R7: a turn-off restarts the full window
  p_dt_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == LOAD_VAL));
  // R7: the window counts down by one per cycle
  p_dt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/leg_gate_ctrl.sv
module leg_gate_ctrl
  import leg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 18,
  parameter int unsigned LVL_W    = 8,
  parameter int unsigned UV_ON    = 120,
  parameter int unsigned UV_OFF   = 105
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_cmd,
  input  logic             lo_cmd_n,
  input  logic             halt_n,
  input  logic [LVL_W-1:0] sup_lvl,
  output logic             gate_hi,
  output logic             gate_lo
);
  logic      uv;
  logic      dt_expired;
  logic      off_evt;
  logic      gate_en;
  leg_pair_t req;
  leg_pair_t gate_q;
  leg_pair_t gate_d;

  leg_uv_hyst #(.LVL_W(LVL_W), .UV_ON(UV_ON), .UV_OFF(UV_OFF)) uv_i (
    .clk(clk), .rst_n(rst_n), .lvl(sup_lvl), .uv_o(uv)
  );

  leg_cmd_decode dec_i (
    .hi_cmd(hi_cmd), .lo_cmd_n(lo_cmd_n), .halt_n(halt_n), .uv(uv), .req(req)
  );

  leg_dead_timer #(.DEAD_CYC(DEAD_CYC)) dt_i (
    .clk(clk), .rst_n(rst_n), .load(off_evt), .expired(dt_expired)
  );

  // next-state: stay on while requested, turn on only with both off and window expired
  always_comb begin
    gate_d.hi = req.hi & (gate_q.hi | (dt_expired & ~gate_q.lo));
    gate_d.lo = req.lo & (gate_q.lo | (dt_expired & ~gate_q.hi));
    off_evt   = (gate_q.hi & ~gate_d.hi) | (gate_q.lo & ~gate_d.lo);
    gate_en   = (gate_d != gate_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gate_q <= '0;
    else if (gate_en) gate_q <= gate_d;
  end

  assign gate_hi = gate_q.hi;
  assign gate_lo = gate_q.lo;

  // R6
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));
  // R4
  p_interlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cmd && !lo_cmd_n) |=> (!gate_hi && !gate_lo));
  // R10
  p_halt_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |=> (!gate_hi && !gate_lo));
  // R11
  p_uv_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> (!gate_hi && !gate_lo));
  // R7: a rising gate needs the window expired and the partner off
  p_rise_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> ($past(dt_expired) && !$past(gate_lo)));
  p_rise_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> ($past(dt_expired) && !$past(gate_hi)));
endmodule

// File: tb/leg_gate_ctrl_tb.sv
`timescale 1ns/1ps
module leg_gate_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD       = 18;
  localparam int NROW       = 14;

  // row: [20]hi [19]lo_n [18]halt_n [17:10]lvl [9:2]wait [1]exp_hi [0]exp_lo
  localparam logic [20:0] TBL [0:NROW-1] = '{
    {3'b011, 8'd200, 8'd2,  2'b00},  // 0  R5 idle
    {3'b111, 8'd200, 8'd2,  2'b10},  // 1  R2 high request
    {3'b101, 8'd200, 8'd2,  2'b00},  // 2  R4 overlap
    {3'b001, 8'd200, 8'd2,  2'b00},  // 3  R7 low request inside window
    {3'b001, 8'd200, 8'd20, 2'b01},  // 4  R3 low request after window
    {3'b011, 8'd200, 8'd2,  2'b00},  // 5  R5 idle
    {3'b001, 8'd200, 8'd2,  2'b00},  // 6  R7 same side blocked
    {3'b001, 8'd200, 8'd20, 2'b01},  // 7  R3 same side after window
    {3'b000, 8'd200, 8'd1,  2'b00},  // 8  R10 halt
    {3'b111, 8'd100, 8'd30, 2'b00},  // 9  R11 below lower threshold
    {3'b111, 8'd110, 8'd30, 2'b00},  // 10 R11 between, stays set
    {3'b111, 8'd130, 8'd30, 2'b10},  // 11 R11 recovered
    {3'b111, 8'd110, 8'd5,  2'b10},  // 12 R11 between, stays clear
    {3'b111, 8'd100, 8'd2,  2'b00}   // 13 R11 drop again
  };
  localparam int TAG [0:NROW-1] = '{5, 2, 4, 7, 3, 5, 7, 3, 10, 11, 11, 11, 11, 11};

  logic       clk;
  logic       rst_n;
  logic       hi_cmd;
  logic       lo_cmd_n;
  logic       halt_n;
  logic [7:0] sup_lvl;
  logic       gate_hi;
  logic       gate_lo;

  int errors  = 0;
  int checks  = 0;
  int overlap = 0;

  leg_gate_ctrl #(.DEAD_CYC(DEAD), .LVL_W(8), .UV_ON(120), .UV_OFF(105)) dut_i (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd_n(lo_cmd_n),
    .halt_n(halt_n), .sup_lvl(sup_lvl), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && gate_hi && gate_lo) overlap++;

  task automatic check(input string req, input logic eh, input logic el);
    checks++;
    if (gate_hi !== eh || gate_lo !== el) begin
      errors++;
      $display("FAIL %s: gates hi/lo = %b%b, expected %b%b", req, gate_hi, gate_lo, eh, el);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic h, input logic ln, input logic hn, input logic [7:0] l);
    hi_cmd = h; lo_cmd_n = ln; halt_n = hn; sup_lvl = l;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    drive(1'b0, 1'b1, 1'b1, 8'd200);
    rst_n = 1'b0;
    #1;
    check("R1 reset state", 1'b0, 1'b0);
    wait_n(3);
    rst_n = 1'b1;

    // vector table
    for (int r = 0; r < NROW; r++) begin
      drive(TBL[r][20], TBL[r][19], TBL[r][18], TBL[r][17:10]);
      wait_n(int'(TBL[r][9:2]));
      checks++;
      if (gate_hi !== TBL[r][1] || gate_lo !== TBL[r][0]) begin
        errors++;
        $display("FAIL row %0d (R%0d): gates hi/lo = %b%b, expected %b%b",
                 r, TAG[r], gate_hi, gate_lo, TBL[r][1], TBL[r][0]);
      end
    end

    // R1 / R12: reset mid-run with a pending request
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 8'd200);
    rst_n = 1'b0;
    #1;
    check("R1 outputs low in reset", 1'b0, 1'b0);
    wait_n(3);
    check("R1 held in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    wait_n(1);
    check("R12 supply flag still set one edge after reset", 1'b0, 1'b0);
    wait_n(1);
    check("R1 first turn-on without dead time", 1'b1, 1'b0);

    // R7: exact opposite-side gap
    drive(1'b0, 1'b0, 1'b1, 8'd200);
    wait_n(1);
    check("R7 high side off at first edge", 1'b0, 1'b0);
    wait_n(DEAD - 1);
    check("R7 low side still held at edge DEAD", 1'b0, 1'b0);
    wait_n(1);
    check("R7 low side on at edge DEAD+1", 1'b0, 1'b1);

    // R9: one signal on both command pins
    drive(1'b1, 1'b1, 1'b1, 8'd200);
    wait_n(1);
    check("R9 tied high: low off first", 1'b0, 1'b0);
    wait_n(DEAD - 1);
    check("R9 tied high: dead time holds", 1'b0, 1'b0);
    wait_n(1);
    check("R9 tied high: high side on", 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 8'd200);
    wait_n(1);
    check("R9 tied low: high off first", 1'b0, 1'b0);
    wait_n(DEAD - 1);
    check("R9 tied low: dead time holds", 1'b0, 1'b0);
    wait_n(1);
    check("R9 tied low: low side on", 1'b0, 1'b1);

    // R8: request well after the window follows at once
    drive(1'b0, 1'b1, 1'b1, 8'd200);
    wait_n(DEAD + 3);
    check("R5 idle before late request", 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 8'd200);
    wait_n(1);
    check("R8 late request follows next edge", 1'b1, 1'b0);

    // R10: halt and dead time after forced off
    drive(1'b1, 1'b1, 1'b0, 8'd200);
    wait_n(1);
    check("R10 halt forces off", 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 8'd200);
    wait_n(1);
    check("R10 dead time after forced off", 1'b0, 1'b0);
    wait_n(DEAD);
    check("R10 resumes after window", 1'b1, 1'b0);

    checks++;
    if (overlap != 0) begin
      errors++;
      $display("FAIL R6: overlapping cycles = %0d, expected 0", overlap);
    end

    summary();
    $finish;
  end
endmodule